// File: doc/BRIEF.md
# Programmable Event Counter Pair

This block holds two 40-bit event counters. Each counter has its own 32-bit function register. On every clock the block receives a per-cycle occurrence count for each of a set of event sources, from 0 to 15 per source, and a privilege-mode flag that says whether the current cycle runs in user or kernel mode.

Each counter picks one source through its function register and then qualifies it:
- by privilege mode;
- by an optional per-cycle threshold, whose sense can be inverted;
- by optional rising-edge detection.

The counter then adds the qualified amount. A single enable flag in counter 0's function register gates both counters. A free-running 64-bit timestamp runs beside the counters, so that counter readings can be placed in time.

Software or a debug agent reaches the block through a small register port. A write stores a function register or loads a counter value. A read returns any function register, any counter or the timestamp one cycle after the address is presented. The block is meant to sit next to a core's event sources for performance analysis.

Top module: `evpair_top`

## Requirements
- R1: Address map: 0 and 1 are the function registers of counters 0 and 1, 2 and 3 are the counter values, and 4 is the timestamp. A write with `wr_en` stores `wr_data` at `wr_addr`: function registers take bits 31:0, counters take bits 39:0. `rd_data` shows the zero-extended content at `rd_addr` one clock edge after the address is sampled. Function bits 15:8 (the unit mask) are stored and read back, but they have no effect on counting.
- R2: The function register fields are as follows. Bits 7:0 select the event source, and a select value with no matching source reads as a count of zero. When the threshold field (bits 31:24) is zero and edge mode is off, the counter adds the full per-cycle count of the selected source.
- R3: When the threshold field is nonzero and invert (bit 23) is clear, the counter adds one in each cycle whose count is at least the threshold, and adds nothing otherwise.
- R4: When the threshold is nonzero and invert is set, the counter adds one in each cycle whose count is at most the threshold.
- R5: With edge mode (bit 18) set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. With a zero threshold, the condition is "count nonzero". A write to the function register clears the stored previous-cycle condition.
- R6: User enable is bit 16 and kernel enable is bit 17. In a cycle with `kernel_mode`=0 a counter counts only if its user enable is set. With `kernel_mode`=1 it counts only if its kernel enable is set. With both enables clear, a counter never counts.
- R7: Bit 22 of counter 0's function register enables both counters. Counter 1 counts only while that bit is set, and bit 22 of counter 1's own function register has no effect.
- R8: A write to a counter value takes priority over that counter's increment in the same cycle. Counters wrap modulo 2^40.
- R9: The timestamp is 0 in the first cycle after reset and then increments by one every clock.
- R10: Reset clears both function registers, both counters and the timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cnt | input | NUM_EVT*CNT_W (64) | Per-cycle occurrence count of each source; source e is at bits e*CNT_W +: CNT_W |
| kernel_mode | input | 1 | 1 = kernel mode this cycle, 0 = user mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Write address |
| wr_data | input | CTR_W (40) | Write data |
| rd_addr | input | ADDR_W (3) | Read address |
| rd_data | output | TS_W (64) | Registered read data |

## Verification
A counter value load and an event increment for the same counter can fall in the same clock. The bench provokes this by writing a value just below the wrap point while the selected source is reporting seven events per cycle. A correct result shows the loaded value advanced by exactly one further cycle of counting, wrapped past 2^40. A function register write and an edge-mode counting cycle can also coincide. This is provoked by rewriting the function register while the condition is held high, and it is judged by the one extra count that follows the cleared history.

// File: rtl/evpair_pkg.sv
package evpair_pkg;

  localparam int FN_W = 32;

  typedef struct packed {
    logic [7:0] cmask;
    logic       inv;
    logic       en;
    logic [2:0] rsvd;
    logic       edge_md;
    logic       krn;
    logic       usr;
    logic [7:0] umask;
    logic [7:0] sel;
  } fn_t;

  localparam int BIT_USR  = 16;
  localparam int BIT_KRN  = 17;
  localparam int BIT_EDGE = 18;
  localparam int BIT_EN   = 22;
  localparam int BIT_INV  = 23;

endpackage

// File: rtl/evpair_qual.sv
module evpair_qual
  import evpair_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fn_t                      fn,
  input  logic                     glb_en,
  input  logic                     kernel_mode,
  input  logic                     fn_wr,
  input  logic [NUM_EVT*CNT_W-1:0] evt_cnt,
  output logic [CNT_W-1:0]         inc
);

  localparam int CMP_W = (CNT_W > 8) ? CNT_W : 8;

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] thr_x;
  logic             cond;
  logic             mode_ok;
  logic             qual;
  logic             prev_q;
  logic             unused_fn_bits;

  assign unused_fn_bits = ^{fn.umask, fn.rsvd, fn.en};

  always_comb begin
    cnt = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (fn.sel == 8'(e)) cnt = evt_cnt[e*CNT_W +: CNT_W];
    end
  end

  assign cnt_x = CMP_W'(cnt);
  assign thr_x = CMP_W'(fn.cmask);

  always_comb begin
    if (fn.cmask == 8'd0)  cond = (cnt != '0);
    else if (fn.inv)       cond = (cnt_x <= thr_x);
    else                   cond = (cnt_x >= thr_x);
  end

  assign mode_ok = kernel_mode ? fn.krn : fn.usr;
  assign qual    = cond & mode_ok & glb_en;

  always_ff @(posedge clk) begin
    if (rst || fn_wr) prev_q <= 1'b0;
    else              prev_q <= qual;
  end

  always_comb begin
    if (!qual)                inc = '0;
    else if (fn.edge_md)      inc = prev_q ? '0 : CNT_W'(1);
    else if (fn.cmask == 8'd0) inc = cnt;
    else                      inc = CNT_W'(1);
  end

endmodule

// File: rtl/evpair_ctr.sv
module evpair_ctr #(
  parameter int W     = 40,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= ld_val;
    else         q <= q + W'(inc);
  end

endmodule

// File: rtl/evpair_tsc.sv
module evpair_tsc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q + W'(1);
  end

endmodule

// File: rtl/evpair_top.sv
module evpair_top
  import evpair_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 4,
  parameter int CTR_W   = 40,
  parameter int TS_W    = 64,
  parameter int NUM_CTR = 2,
  parameter int ADDR_W  = $clog2(2*NUM_CTR+1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_EVT*CNT_W-1:0] evt_cnt,
  input  logic                     kernel_mode,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CTR_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [TS_W-1:0]          rd_data
);

  localparam logic [ADDR_W-1:0] TS_A = ADDR_W'(2*NUM_CTR);

  fn_t              fn_q  [NUM_CTR];
  logic [CTR_W-1:0] ctr_q [NUM_CTR];
  logic [TS_W-1:0]  ts_q;
  logic [TS_W-1:0]  rd_mux;
  logic             glb_en;

  assign glb_en = fn_q[0].en;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [ADDR_W-1:0] FN_A = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] CT_A = ADDR_W'(NUM_CTR + i);

    logic             fn_wr;
    logic             ct_wr;
    logic [CNT_W-1:0] inc;

    assign fn_wr = wr_en && (wr_addr == FN_A);
    assign ct_wr = wr_en && (wr_addr == CT_A);

    always_ff @(posedge clk) begin
      if (rst)        fn_q[i] <= '0;
      else if (fn_wr) fn_q[i] <= fn_t'(wr_data[FN_W-1:0]);
    end

    evpair_qual #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_qual (
      .clk(clk), .rst(rst), .fn(fn_q[i]), .glb_en(glb_en),
      .kernel_mode(kernel_mode), .fn_wr(fn_wr), .evt_cnt(evt_cnt), .inc(inc)
    );

    evpair_ctr #(.W(CTR_W), .INC_W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .ld(ct_wr), .ld_val(wr_data), .inc(inc), .q(ctr_q[i])
    );
  end

  evpair_tsc #(.W(TS_W)) u_tsc (.clk(clk), .rst(rst), .q(ts_q));

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_addr == ADDR_W'(i))           rd_mux = TS_W'(fn_q[i]);
      if (rd_addr == ADDR_W'(NUM_CTR + i)) rd_mux = TS_W'(ctr_q[i]);
    end
    if (rd_addr == TS_A) rd_mux = ts_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

endmodule

// File: rtl/evpair_chk.sv
module evpair_chk
  import evpair_pkg::*;
#(
  parameter int CTR_W  = 40,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CTR_W-1:0]  wr_data,
  input logic [31:0]       fn0,
  input logic [31:0]       fn1,
  input logic [CTR_W-1:0]  ctr0,
  input logic [CTR_W-1:0]  ctr1,
  input logic [TS_W-1:0]   ts
);

  logic ld0, ld1;
  assign ld0 = wr_en && (wr_addr == ADDR_W'(2));
  assign ld1 = wr_en && (wr_addr == ADDR_W'(3));

  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld0 |=> ctr0 == $past(wr_data));

  a_r7_global_gate: assert property (@(posedge clk) disable iff (rst)
    (!fn0[BIT_EN] && !ld1) |=> ctr1 == $past(ctr1));

  a_r6_no_mode: assert property (@(posedge clk) disable iff (rst)
    (!fn0[BIT_USR] && !fn0[BIT_KRN] && !ld0) |=> ctr0 == $past(ctr0));

  a_r5_edge_step: assert property (@(posedge clk) disable iff (rst)
    (fn0[BIT_EDGE] && !ld0) |=> (ctr0 - $past(ctr0)) <= CTR_W'(1));

  a_r2_max_step: assert property (@(posedge clk) disable iff (rst)
    !ld1 |=> (ctr1 - $past(ctr1)) <= CTR_W'(15));

  a_r9_ts_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ts == $past(ts) + TS_W'(1));

  logic unused_fn1;
  assign unused_fn1 = ^fn1;

endmodule

bind evpair_top evpair_chk #(.CTR_W(CTR_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fn0(fn_q[0]), .fn1(fn_q[1]), .ctr0(ctr_q[0]), .ctr1(ctr_q[1]), .ts(ts_q)
);

// File: tb/tb_evpair_top.sv
`timescale 1ns/1ps
module tb_evpair_top;

  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] evt_cnt = '0;
  logic        kernel_mode = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [39:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evpair_top dut (.*);

  // {req[60:57], fn[56:25], mode[24], four counts[23:8] (first in 23:20), expected[7:0]}
  localparam logic [60:0] VEC [13] = '{
    {4'd2,  32'h0041_0003, 1'b0, 16'h205F, 8'd22},
    {4'd6,  32'h0042_0003, 1'b1, 16'h1111, 8'd4},
    {4'd3,  32'h0341_0003, 1'b0, 16'h2341, 8'd2},
    {4'd4,  32'h03C1_0003, 1'b0, 16'h2341, 8'd3},
    {4'd5,  32'h0045_0003, 1'b0, 16'h1203, 8'd2},
    {4'd5,  32'h0245_0003, 1'b0, 16'h3122, 8'd2},
    {4'd5,  32'h01C5_0003, 1'b0, 16'h0510, 8'd2},
    {4'd3,  32'h0F42_0003, 1'b1, 16'hFEFF, 8'd3},
    {4'd2,  32'h0041_0014, 1'b0, 16'h5555, 8'd0},
    {4'd6,  32'h0040_0003, 1'b0, 16'h5555, 8'd0},
    {4'd6,  32'h0041_0003, 1'b1, 16'h5555, 8'd0},
    {4'd1,  32'h0041_FF03, 1'b0, 16'h205F, 8'd22},
    {4'd2,  32'h0041_0002, 1'b0, 16'h5555, 8'd0}
  };

  function automatic string tag(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_evt(input logic [3:0] v);
    evt_cnt = '0;
    evt_cnt[3*4 +: 4] = v;
  endtask

  task automatic wr(input logic [2:0] a, input logic [39:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] v, t1, t2;
    repeat (3) @(negedge clk);
    rst = 0;

    // R10 / R9: reset state
    rd(3'd4, v); check("R9", v, 64'd0);
    rd(3'd2, v); check("R10", v, 64'd0);
    rd(3'd3, v); check("R10", v, 64'd0);
    rd(3'd0, v); check("R10", v, 64'd0);

    // vector walk on counter 0, source 3
    for (int i = 0; i < 13; i++) begin
      logic m;
      m = VEC[i][24];
      kernel_mode = ~m; set_evt(4'd0);
      wr(3'd0, {8'd0, VEC[i][56:25]});
      wr(3'd2, 40'd0);
      kernel_mode = m;
      for (int k = 0; k < 4; k++) begin
        set_evt(VEC[i][23 - 4*k -: 4]);
        @(negedge clk);
      end
      set_evt(4'd0); kernel_mode = ~m;
      wr(3'd0, 40'd0);
      rd(3'd2, v);
      check(tag(int'(VEC[i][60:57])), v, 64'(VEC[i][7:0]));
    end

    // R1: function register readback including unit mask
    wr(3'd1, 40'hFF_A5C3_1234);
    rd(3'd1, v); check("R1", v, 64'hA5C3_1234);

    // R7: counter 1 gated by counter 0 enable bit
    kernel_mode = 0; set_evt(4'd0);
    wr(3'd0, 40'd0);
    wr(3'd1, 40'h0041_0003);
    wr(3'd3, 40'd0);
    set_evt(4'd4); repeat (3) @(negedge clk); set_evt(4'd0);
    rd(3'd3, v); check("R7", v, 64'd0);
    wr(3'd0, 40'h0040_0000);
    wr(3'd1, 40'h0001_0003);
    wr(3'd3, 40'd0);
    set_evt(4'd4); repeat (3) @(negedge clk); set_evt(4'd0);
    rd(3'd3, v); check("R7", v, 64'd12);

    // R8: load beats increment in the same cycle, then wrap
    wr(3'd0, 40'h0041_0003);
    set_evt(4'd7);
    wr(3'd2, 40'hFF_FFFF_FFFE);
    @(negedge clk);
    set_evt(4'd0);
    rd(3'd2, v); check("R8", v, 64'd5);

    // R5: function write clears edge history while condition held
    kernel_mode = 1;
    wr(3'd0, 40'h0045_0003);
    set_evt(4'd1); kernel_mode = 0;
    wr(3'd2, 40'd0);
    repeat (3) @(negedge clk);
    wr(3'd0, 40'h0045_0003);
    repeat (2) @(negedge clk);
    set_evt(4'd0);
    rd(3'd2, v); check("R5", v, 64'd1);

    // R9: timestamp advances one per clock
    rd(3'd4, t1);
    repeat (9) @(negedge clk);
    rd(3'd4, t2);
    check("R9", t2 - t1, 64'd10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule